// File: doc/BRIEF.md
# UART Start-Frame Wake Detector

This block sits beside a UART receiver and watches the receive line while the rest of the system sleeps. When the line falls from idle to a start bit, the detector acts according to one of two wake policies. In the start-wake policy it latches a start flag, which can raise a start interrupt and ask the system to wake straight away. In the receive-complete policy it requests the oscillator and enables the receiver clock for exactly one frame, so that the receiver can capture the byte; the system is then woken by the receive-complete event, and the clocks drop again.

Software controls the block through one byte-wide control/status register with read and write strobes. It holds a start-interrupt enable, the start flag and a detection enable. The policy is picked by combining the detection enable and the start-interrupt enable with the receive-complete interrupt enable of the receiver. The receive line is taken through a synchronizer, and only a level taken from that synchronizer is used, so the same detector serves both asynchronous and clocked receive modes.

Top module: `uart_sof_wake`

## Requirements
- R1: The control/status register resets to 0x20. Bit 7 is the start-interrupt enable, bit 6 the start flag, bit 5 the detection enable, and bits 4..0 always read as zero. `reg_rdata_o` is zero whenever `reg_rd_i` is low.
- R2: The start flag sets on a high-to-low transition of `rxd_i`, seen through the synchronizer. The flag is visible three rising edges after the edge at which `rxd_i` is first sampled low and not after two. A line that is low from reset and has never been seen high does not set the flag.
- R3: Writing a one to bit 6 clears the start flag. Writing a zero there leaves the flag unchanged. A detection in the same cycle as the clear wins over it.
- R4: `start_irq_o` is high exactly when the start-interrupt enable, `gie_i` and the start flag are all one.
- R5: With the detection enable at 0, or with the detection enable at 1 and both the start-interrupt enable and `rxc_ie_i` at 0 (the reserved combination), a falling edge sets no flag and opens no clock window.
- R6: Start-wake policy (detection enable 1, start-interrupt enable 1): during sleep, `wake_o` is high while `gie_i` and the start flag are one. No clock window is opened.
- R7: Receive-complete policy (detection enable 1, start-interrupt enable 0, `rxc_ie_i` 1): a falling edge during sleep raises `osc_req_o` and `rx_clk_en_o` together, in the same cycle as the flag. Both stay high until `frame_done_i` pulses and are low in the cycle after that pulse.
- R8: In the receive-complete policy, the `frame_done_i` pulse that closes the window raises `wake_o` for one cycle, in the cycle in which the clocks drop, provided `gie_i` and `sleep_i` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Detector clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | UART receive line, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, zero when not reading |
| sleep_i | input | 1 | System is in a sleep state |
| gie_i | input | 1 | Global interrupt enable |
| rxc_ie_i | input | 1 | Receive-complete interrupt enable from the receiver |
| frame_done_i | input | 1 | One-cycle pulse when the receiver finishes a frame |
| osc_req_o | output | 1 | Oscillator request |
| rx_clk_en_o | output | 1 | Receiver clock enable |
| wake_o | output | 1 | Wake request to the power controller |
| start_irq_o | output | 1 | Start interrupt |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer and the 0x20 reset image. With these values the three-edge latency from line to flag and clock window is fixed, so the bench can check the exact cycle in which the flag rises, the cycle in which the window opens, and the cycle in which the clocks drop after `frame_done_i`. The tests cover both wake policies, the disabled and reserved combinations, and a line held low from reset.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

  // Bit positions inside the control/status byte
  localparam int unsigned CSR_W    = 8;
  localparam int unsigned BIT_SIE  = 7;
  localparam int unsigned BIT_FLAG = 6;
  localparam int unsigned BIT_EN   = 5;

  typedef enum logic [1:0] {
    SFD_OFF        = 2'd0,
    SFD_START_WAKE = 2'd1,
    SFD_RXC_WAKE   = 2'd2
  } sfd_mode_e;

  // Policy decode; the reserved combination (no interrupt enable) maps to off.
  function automatic sfd_mode_e sfd_decode(input logic en, input logic sie,
                                           input logic rxcie);
    sfd_mode_e m;
    if (!en)      m = SFD_OFF;
    else if (sie) m = SFD_START_WAKE;
    else if (rxcie) m = SFD_RXC_WAKE;
    else          m = SFD_OFF;
    return m;
  endfunction

endpackage

// File: rtl/sfd_edge.sv
module sfd_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic fall_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] sync_q, sync_d;
  logic          prev_q, prev_d;

  generate
    if (STAGES > 1) begin : g_chain
      always_comb sync_d = {sync_q[LAST-1:0], line_i};
    end else begin : g_single
      always_comb sync_d = line_i;
    end
  endgenerate

  always_comb prev_d = sync_q[LAST];

  // prev resets low: a fall needs the line to have been seen high first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign fall_o = prev_q & ~sync_q[LAST];

  // R2
  fall_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/sfd_csr.sv
module sfd_csr
  import sfd_pkg::*;
#(
  parameter logic [CSR_W-1:0] RST_VAL = 8'h20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [CSR_W-1:0] wdata_i,
  input  logic             fall_i,
  input  logic             det_on_i,
  output logic [CSR_W-1:0] rdata_o,
  output logic             sie_o,
  output logic             flag_o,
  output logic             en_o
);

  logic sie_q, en_q, flag_q;
  logic sie_d, en_d, flag_d;
  logic ctl_ce, flag_ce;
  logic set_flag, clr_flag;
  logic [CSR_W-1:0] image;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i;

  assign set_flag = det_on_i & fall_i;
  assign clr_flag = wr_i & wdata_i[BIT_FLAG];
  assign ctl_ce   = wr_i;
  assign flag_ce  = set_flag | clr_flag;

  always_comb begin
    sie_d  = wdata_i[BIT_SIE];
    en_d   = wdata_i[BIT_EN];
    flag_d = set_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sie_q  <= RST_VAL[BIT_SIE];
      en_q   <= RST_VAL[BIT_EN];
      flag_q <= RST_VAL[BIT_FLAG];
    end else begin
      if (ctl_ce) begin
        sie_q <= sie_d;
        en_q  <= en_d;
      end
      if (flag_ce) flag_q <= flag_d;
    end
  end

  always_comb begin
    image           = '0;
    image[BIT_SIE]  = sie_q;
    image[BIT_FLAG] = flag_q;
    image[BIT_EN]   = en_q;
  end

  assign rdata_o = rd_i ? image : '0;
  assign sie_o   = sie_q;
  assign flag_o  = flag_q;
  assign en_o    = en_q;

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flag && !set_flag) |=> !flag_o);

  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_flag |=> flag_o);

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_flag && !clr_flag) |=> $stable(flag_o));

  // R1
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[4:0] == 5'd0);

endmodule

// File: rtl/sfd_policy.sv
module sfd_policy
  import sfd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sfd_mode_e mode_i,
  input  logic      fall_i,
  input  logic      sleep_i,
  input  logic      gie_i,
  input  logic      frame_done_i,
  output logic      win_o,
  output logic      rxc_wake_o
);

  logic win_q, win_d;
  logic wake_q, wake_d;
  logic rxc_mode;

  assign rxc_mode = (mode_i == SFD_RXC_WAKE);

  always_comb begin
    win_d = win_q;
    if (!rxc_mode)                  win_d = 1'b0;
    else if (win_q && frame_done_i) win_d = 1'b0;
    else if (fall_i && sleep_i)     win_d = 1'b1;
  end

  always_comb wake_d = rxc_mode & win_q & frame_done_i & gie_i & sleep_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      win_q  <= win_d;
      wake_q <= wake_d;
    end
  end

  assign win_o      = win_q;
  assign rxc_wake_o = wake_q;

  // R7
  win_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_o && frame_done_i) |=> !win_o);

  // R5
  win_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SFD_OFF) |=> !win_o);

  // R8
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxc_wake_o |=> !rxc_wake_o);

endmodule

// File: rtl/uart_sof_wake.sv
module uart_sof_wake
  import sfd_pkg::*;
#(
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [CSR_W-1:0] CSR_RST     = 8'h20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [CSR_W-1:0] reg_wdata_i,
  output logic [CSR_W-1:0] reg_rdata_o,
  input  logic             sleep_i,
  input  logic             gie_i,
  input  logic             rxc_ie_i,
  input  logic             frame_done_i,
  output logic             osc_req_o,
  output logic             rx_clk_en_o,
  output logic             wake_o,
  output logic             start_irq_o
);

  logic      fall;
  logic      sie, flag, en;
  logic      det_on;
  logic      win, rxc_wake;
  sfd_mode_e mode;

  sfd_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (rxd_i),
    .fall_o (fall)
  );

  assign mode   = sfd_decode(en, sie, rxc_ie_i);
  assign det_on = (mode != SFD_OFF);

  sfd_csr #(.RST_VAL(CSR_RST)) u_csr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (reg_wr_i),
    .rd_i     (reg_rd_i),
    .wdata_i  (reg_wdata_i),
    .fall_i   (fall),
    .det_on_i (det_on),
    .rdata_o  (reg_rdata_o),
    .sie_o    (sie),
    .flag_o   (flag),
    .en_o     (en)
  );

  sfd_policy u_policy (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode),
    .fall_i       (fall),
    .sleep_i      (sleep_i),
    .gie_i        (gie_i),
    .frame_done_i (frame_done_i),
    .win_o        (win),
    .rxc_wake_o   (rxc_wake)
  );

  assign osc_req_o   = win;
  assign rx_clk_en_o = win;
  assign start_irq_o = sie & gie_i & flag;
  assign wake_o      = sleep_i & (((mode == SFD_START_WAKE) & gie_i & flag) | rxc_wake);

  // R4
  irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_irq_o |-> gie_i);

  // R6
  wake_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> sleep_i);

  // R6
  no_win_start_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SFD_START_WAKE) |=> !osc_req_o);

endmodule

// File: tb/uart_sof_wake_test.sv
module uart_sof_wake_test;

  localparam time CLK_P = 8ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rxd, wr, rd, sleep, gie, rxcie, fdone;
  logic [7:0] wdata, rdata;
  logic       osc, rxclk, wake, irq;

  int vectors = 0;
  int misses  = 0;
  bit ended   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  uart_sof_wake uut (
    .clk (clk), .rst_n (rst_n), .rxd_i (rxd),
    .reg_wr_i (wr), .reg_rd_i (rd), .reg_wdata_i (wdata), .reg_rdata_o (rdata),
    .sleep_i (sleep), .gie_i (gie), .rxc_ie_i (rxcie), .frame_done_i (fdone),
    .osc_req_o (osc), .rx_clk_en_o (rxclk), .wake_o (wake), .start_irq_o (irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] v);
    wr = 1'b1; wdata = v;
    step(1);
    wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic rd_reg(output logic [7:0] v);
    rd = 1'b1;
    #1 v = rdata;
    rd = 1'b0;
    step(1);
  endtask

  // Drop the line; after three edges the flag and window are expected.
  task automatic fall_line();
    rxd = 1'b0;
    step(3);
  endtask

  task automatic idle_line();
    rxd = 1'b1;
    step(4);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rxcie = 1'b1;
    rxd   = 1'b0;
    step(6);
    check("R1 rdata idle", rdata, 8'h00);
    rd_reg(v);
    check("R1 reset image", v, 8'h20);
    check("R2 low from reset no flag", v[6], 1'b0);
    check("R7 no clock at reset", osc, 1'b0);
    check("R4 no irq at reset", irq, 1'b0);
  endtask

  task automatic t_latency();
    logic [7:0] v;
    idle_line();
    rxd = 1'b0;
    step(2);
    rd_reg(v);
    check("R2 not after two edges", v[6], 1'b0);
    rd_reg(v);
    check("R2 flag set", v[6], 1'b1);
    idle_line();
  endtask

  task automatic t_clear();
    logic [7:0] v;
    wr_reg(8'h20);
    rd_reg(v);
    check("R3 write zero keeps flag", v, 8'h60);
    wr_reg(8'h60);
    rd_reg(v);
    check("R3 write one clears flag", v, 8'h20);
  endtask

  task automatic t_start_wake();
    logic [7:0] v;
    rxcie = 1'b0; gie = 1'b1;
    wr_reg(8'hA0);
    fall_line();
    check("R4 irq raised", irq, 1'b1);
    gie = 1'b0; #1;
    check("R4 irq masked by gie", irq, 1'b0);
    sleep = 1'b1; gie = 1'b1; #1;
    check("R6 wake on flag", wake, 1'b1);
    check("R6 no clock window", osc, 1'b0);
    idle_line();
    wr_reg(8'hE0);
    #1;
    check("R4 irq gone after clear", irq, 1'b0);
    check("R6 wake gone after clear", wake, 1'b0);
    rd_reg(v);
    check("R3 cleared in start mode", v, 8'hA0);
    sleep = 1'b0;
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    wr_reg(8'h80);
    sleep = 1'b1;
    fall_line();
    rd_reg(v);
    check("R5 disabled no flag", v, 8'h80);
    check("R5 disabled no irq", irq, 1'b0);
    idle_line();
    wr_reg(8'h20);
    rxcie = 1'b0;
    fall_line();
    rd_reg(v);
    check("R5 reserved no flag", v, 8'h20);
    check("R5 reserved no clock", osc, 1'b0);
    idle_line();
    sleep = 1'b0;
  endtask

  task automatic t_rxc_wake();
    rxcie = 1'b1; sleep = 1'b1; gie = 1'b1;
    wr_reg(8'h20);
    rxd = 1'b0;
    step(2);
    check("R7 window not after two edges", osc, 1'b0);
    step(1);
    check("R7 osc request", osc, 1'b1);
    check("R7 rx clock enable", rxclk, 1'b1);
    check("R4 no irq in rxc mode", irq, 1'b0);
    check("R8 no wake yet", wake, 1'b0);
    rxd = 1'b1;
    step(10);
    check("R7 window held", {osc, rxclk}, 2'b11);
    fdone = 1'b1;
    step(1);
    fdone = 1'b0;
    check("R7 clocks drop after done", {osc, rxclk}, 2'b00);
    check("R8 wake pulse", wake, 1'b1);
    step(1);
    check("R8 wake pulse ends", wake, 1'b0);
    wr_reg(8'h60);
    sleep = 1'b0;
  endtask

  task automatic t_low_bits();
    logic [7:0] v;
    wr_reg(8'hFF);
    rd_reg(v);
    check("R1 low bits read zero", v, 8'hA0);
  endtask

  initial begin
    rst_n = 1'b0; rxd = 1'b0; wr = 1'b0; rd = 1'b0; wdata = 8'h00;
    sleep = 1'b0; gie = 1'b0; rxcie = 1'b0; fdone = 1'b0;
    step(3);
    rst_n = 1'b1;
    t_reset();
    t_latency();
    t_clear();
    t_start_wake();
    t_disabled();
    t_rxc_wake();
    t_low_bits();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!ended) begin
      ended = 1'b1;
      vectors++;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule